// File: doc/BRIEF.md
# Three-Wire Synthesizer Configuration Port

This block receives configuration words for a dual-channel frequency synthesizer (an IF channel and an RF channel) over a three-wire serial link: a serial clock, a data line and a load strobe. The three pins are brought into the system clock domain through two-flop synchronizers. Serial bits are shifted into a 22-bit frame register on each detected rising edge of the serial clock, most significant bit first. A rising edge on the load strobe copies the 20-bit payload into one of four holding registers. The target register is chosen by the two address bits that close the frame.

Each channel owns two holding registers. The reference register carries the reference divide ratio and five mode flags. The divider register carries the swallow count A, the main count B, the prescaler-pair select and the channel power-down bit. The decoded fields are presented at the ports for the divider, detector and charge-pump logic. The block also combines the pump high-impedance flag with the power-down bit into a four-state power mode for each channel. It turns that mode into a powered-down indication that takes effect either at once or only when the channel's pump reports idle. A shared oscillator-disable output is raised only when both channels request power-down.

Top module: `synth_cfg_port`

## Requirements
- R1: After reset, every holding register is zero. All decoded fields, both power modes, both powered-down outputs, both pump-off outputs and the oscillator-disable output read 0.
- R2: Only the last 22 bits shifted before the load strobe form the frame; earlier bits are pushed out. The first of those 22 bits is payload bit 20, the last payload bit is bit 1, and the final two bits are address bits C1 then C2.
- R3: Address {C1,C2} selects the destination: 00 IF reference, 01 RF reference, 10 IF divider, 11 RF divider. The other three registers keep their values.
- R4: A holding register changes only on a rising edge of the load strobe. Shifting bits with the strobe low leaves every output unchanged.
- R5: Reference register layout: payload bits 15..1 are the reference ratio. Bits 16..20 appear on the flags output at positions 0..4: polarity, current select, pump high-impedance, lock-detect select and monitor select.
- R6: Divider register layout: bits 7..1 are A, bits 18..8 are B, bit 19 is the prescaler select and bit 20 is power-down. On the IF channel only A bits 4..1 are kept, and A bits 7..5 read as zero.
- R7: Power mode code per channel, from reference bit 18 (R18) and divider bit 20 (N20): R18=0,N20=0 gives 0 (active); R18=1,N20=0 gives 1 (active, pump high-impedance); R18=0,N20=1 gives 2 (synchronous power-down); R18=1,N20=1 gives 3 (asynchronous power-down).
- R8: In mode 3 the channel's powered-down output is set on the next system clock, whatever the pump-idle input says.
- R9: In mode 2 the powered-down output rises only on a cycle after the pump-idle input is high. While the pump is busy it stays low.
- R10: Clearing N20 (mode 0 or 1) drops the powered-down output on the next system clock.
- R11: The oscillator-disable output is high exactly when both channels' N20 bits are set.
- R12: A channel's pump-off output is high whenever its pump high-impedance flag or its powered-down output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe, transfer on rising edge |
| if_pump_idle | input | 1 | IF pump reports no correction in progress |
| rf_pump_idle | input | 1 | RF pump reports no correction in progress |
| if_ref_div | output | 15 | IF reference ratio |
| if_ref_flags | output | 5 | IF flags: polarity, current, pump high-Z, lock select, monitor select |
| if_a | output | 7 | IF swallow count (upper 3 bits zero) |
| if_b | output | 11 | IF main count |
| if_presc_hi | output | 1 | IF larger prescaler pair selected |
| if_pd_mode | output | 2 | IF power mode code |
| if_powered_down | output | 1 | IF channel powered down |
| if_pump_off | output | 1 | IF pump held in high impedance |
| rf_ref_div | output | 15 | RF reference ratio |
| rf_ref_flags | output | 5 | RF flags, same order as IF |
| rf_a | output | 7 | RF swallow count |
| rf_b | output | 11 | RF main count |
| rf_presc_hi | output | 1 | RF larger prescaler pair selected |
| rf_pd_mode | output | 2 | RF power mode code |
| rf_powered_down | output | 1 | RF channel powered down |
| rf_pump_off | output | 1 | RF pump held in high impedance |
| osc_off | output | 1 | Shared oscillator stage disabled |

## Verification
The hardest state to reach from the ports is a channel that sits in synchronous power-down while its pump stays busy. Getting there takes two frames to two different registers, the reference register with R18 clear and the divider register with N20 set, while the pump-idle input is held low. Only then does releasing pump idle show the delayed power-down. The stimulus builds that sequence on the RF channel while the IF channel is already in asynchronous power-down. This also covers the oscillator-disable rule across both channels, and clearing the IF N20 afterwards covers power-up.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;

  localparam int CH_IF = 0;
  localparam int CH_RF = 1;
  localparam int NUM_CH = 2;

  // positions inside the 5-bit reference flag group
  localparam int FLG_POL  = 0;
  localparam int FLG_CUR  = 1;
  localparam int FLG_HIZ  = 2;
  localparam int FLG_LD   = 3;
  localparam int FLG_MON  = 4;
  localparam int FLG_W    = 5;

  typedef enum logic [1:0] {
    PD_ACTIVE   = 2'd0,
    PD_PUMP_OFF = 2'd1,
    PD_SYNC     = 2'd2,
    PD_ASYNC    = 2'd3
  } pd_mode_e;

  // power mode from the pump high-Z flag and the power-down bit
  function automatic pd_mode_e pd_decode(input logic hiz_bit, input logic pd_bit);
    return pd_mode_e'({pd_bit, hiz_bit});
  endfunction

  // next powered-down state for one channel
  function automatic logic pd_next(input pd_mode_e mode, input logic cur,
                                   input logic pump_idle);
    case (mode)
      PD_ASYNC: return 1'b1;
      PD_SYNC:  return cur | pump_idle;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/sync_bus.sv
module sync_bus #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);

  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= '0;
        end else if (s == 0) begin
          stage_q[s] <= async_in;
        end else begin
          stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
  parameter int FRAME_W = 22
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               bit_in,
  output logic [FRAME_W-1:0] frame
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame <= '0;
    end else if (shift_en) begin
      frame <= {frame[FRAME_W-2:0], bit_in};
    end
  end

endmodule

// File: rtl/chan_cfg.sv
module chan_cfg
  import synth_cfg_pkg::*;
#(
  parameter int REF_W  = 15,
  parameter int A_W    = 7,
  parameter int B_W    = 11,
  parameter int A_KEEP = 7,
  localparam int PAY_W = REF_W + FLG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ref,
  input  logic             wr_div,
  input  logic [PAY_W-1:0] payload,
  input  logic             pump_idle,
  output logic [REF_W-1:0] ref_div,
  output logic [FLG_W-1:0] ref_flags,
  output logic [A_W-1:0]   a_val,
  output logic [B_W-1:0]   b_val,
  output logic             presc_hi,
  output logic             pd_bit,
  output pd_mode_e         pd_mode,
  output logic             powered_down,
  output logic             pump_off
);

  localparam logic [PAY_W-1:0] A_DROP =
    (PAY_W'(1) << A_W) - (PAY_W'(1) << A_KEEP);
  localparam logic [PAY_W-1:0] DIV_MASK = ~A_DROP;

  logic [PAY_W-1:0] ref_q;
  logic [PAY_W-1:0] div_q;
  logic             pd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
      div_q <= '0;
    end else begin
      if (wr_ref) ref_q <= payload;
      if (wr_div) div_q <= payload & DIV_MASK;
    end
  end

  assign ref_div   = ref_q[REF_W-1:0];
  assign ref_flags = ref_q[REF_W +: FLG_W];
  assign a_val     = div_q[A_W-1:0];
  assign b_val     = div_q[A_W +: B_W];
  assign presc_hi  = div_q[A_W+B_W];
  assign pd_bit    = div_q[A_W+B_W+1];

  assign pd_mode = pd_decode(ref_flags[FLG_HIZ], pd_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pd_q <= 1'b0;
    else        pd_q <= pd_next(pd_mode, pd_q, pump_idle);
  end

  assign powered_down = pd_q;
  assign pump_off     = ref_flags[FLG_HIZ] | pd_q;

endmodule

// File: rtl/synth_cfg_port.sv
module synth_cfg_port
  import synth_cfg_pkg::*;
#(
  parameter int REF_W   = 15,
  parameter int A_W     = 7,
  parameter int B_W     = 11,
  parameter int IF_A_W  = 4,
  parameter int SYNC_ST = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_data,
  input  logic             ser_le,
  input  logic             if_pump_idle,
  input  logic             rf_pump_idle,
  output logic [REF_W-1:0] if_ref_div,
  output logic [4:0]       if_ref_flags,
  output logic [A_W-1:0]   if_a,
  output logic [B_W-1:0]   if_b,
  output logic             if_presc_hi,
  output logic [1:0]       if_pd_mode,
  output logic             if_powered_down,
  output logic             if_pump_off,
  output logic [REF_W-1:0] rf_ref_div,
  output logic [4:0]       rf_ref_flags,
  output logic [A_W-1:0]   rf_a,
  output logic [B_W-1:0]   rf_b,
  output logic             rf_presc_hi,
  output logic [1:0]       rf_pd_mode,
  output logic             rf_powered_down,
  output logic             rf_pump_off,
  output logic             osc_off
);

  localparam int PAY_W   = REF_W + FLG_W;
  localparam int FRAME_W = PAY_W + 2;

  logic [2:0]         pins_s;
  logic               sclk_s, sdat_s, sle_s;
  logic               sclk_d, sle_d;
  logic               clk_rise, le_rise;
  logic [FRAME_W-1:0] frame;
  logic [PAY_W-1:0]   payload;
  logic               addr_div, addr_ch;

  sync_bus #(.W(3), .STAGES(SYNC_ST)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({ser_le, ser_data, ser_clk}),
    .sync_out(pins_s)
  );

  assign {sle_s, sdat_s, sclk_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      sle_d  <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      sle_d  <= sle_s;
    end
  end

  assign clk_rise = sclk_s & ~sclk_d;
  assign le_rise  = sle_s & ~sle_d;

  cfg_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .shift_en(clk_rise), .bit_in(sdat_s),
    .frame(frame)
  );

  assign payload  = frame[FRAME_W-1:2];
  assign addr_div = frame[1];   // C1: reference (0) or divider (1)
  assign addr_ch  = frame[0];   // C2: IF (0) or RF (1)

  logic [REF_W-1:0] ref_div_c [NUM_CH];
  logic [FLG_W-1:0] flags_c   [NUM_CH];
  logic [A_W-1:0]   a_c       [NUM_CH];
  logic [B_W-1:0]   b_c       [NUM_CH];
  logic             presc_c   [NUM_CH];
  logic             pdbit_c   [NUM_CH];
  pd_mode_e         mode_c    [NUM_CH];
  logic             down_c    [NUM_CH];
  logic             poff_c    [NUM_CH];
  logic             idle_c    [NUM_CH];

  assign idle_c[CH_IF] = if_pump_idle;
  assign idle_c[CH_RF] = rf_pump_idle;

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      logic wr_ref_c, wr_div_c;
      assign wr_ref_c = le_rise & ~addr_div & (addr_ch == ch[0]);
      assign wr_div_c = le_rise &  addr_div & (addr_ch == ch[0]);

      chan_cfg #(
        .REF_W(REF_W), .A_W(A_W), .B_W(B_W),
        .A_KEEP((ch == CH_IF) ? IF_A_W : A_W)
      ) u_chan (
        .clk(clk), .rst_n(rst_n),
        .wr_ref(wr_ref_c), .wr_div(wr_div_c),
        .payload(payload), .pump_idle(idle_c[ch]),
        .ref_div(ref_div_c[ch]), .ref_flags(flags_c[ch]),
        .a_val(a_c[ch]), .b_val(b_c[ch]),
        .presc_hi(presc_c[ch]), .pd_bit(pdbit_c[ch]),
        .pd_mode(mode_c[ch]), .powered_down(down_c[ch]),
        .pump_off(poff_c[ch])
      );
    end
  endgenerate

  assign if_ref_div      = ref_div_c[CH_IF];
  assign if_ref_flags    = flags_c[CH_IF];
  assign if_a            = a_c[CH_IF];
  assign if_b            = b_c[CH_IF];
  assign if_presc_hi     = presc_c[CH_IF];
  assign if_pd_mode      = mode_c[CH_IF];
  assign if_powered_down = down_c[CH_IF];
  assign if_pump_off     = poff_c[CH_IF];

  assign rf_ref_div      = ref_div_c[CH_RF];
  assign rf_ref_flags    = flags_c[CH_RF];
  assign rf_a            = a_c[CH_RF];
  assign rf_b            = b_c[CH_RF];
  assign rf_presc_hi     = presc_c[CH_RF];
  assign rf_pd_mode      = mode_c[CH_RF];
  assign rf_powered_down = down_c[CH_RF];
  assign rf_pump_off     = poff_c[CH_RF];

  assign osc_off = pdbit_c[CH_IF] & pdbit_c[CH_RF];

endmodule

// File: rtl/synth_cfg_port_chk.sv
module synth_cfg_port_chk #(
  parameter int REF_W = 15,
  parameter int A_W   = 7,
  parameter int B_W   = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             le_rise,
  input logic             if_pump_idle,
  input logic             rf_pump_idle,
  input logic [REF_W-1:0] if_ref_div,
  input logic [4:0]       if_ref_flags,
  input logic [A_W-1:0]   if_a,
  input logic [B_W-1:0]   if_b,
  input logic [REF_W-1:0] rf_ref_div,
  input logic [4:0]       rf_ref_flags,
  input logic [A_W-1:0]   rf_a,
  input logic [B_W-1:0]   rf_b,
  input logic [1:0]       if_pd_mode,
  input logic [1:0]       rf_pd_mode,
  input logic             if_powered_down,
  input logic             rf_powered_down,
  input logic             if_pump_off,
  input logic             rf_pump_off,
  input logic             osc_off
);

  assert_hold_without_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !le_rise |=> $stable({if_ref_div, if_ref_flags, if_a, if_b,
                          rf_ref_div, rf_ref_flags, rf_a, rf_b}));

  assert_if_async_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (if_pd_mode == 2'd3) |=> if_powered_down);

  assert_rf_async_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_pd_mode == 2'd3) |=> rf_powered_down);

  assert_if_sync_waits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (if_pd_mode == 2'd2 && !if_powered_down && !if_pump_idle) |=> !if_powered_down);

  assert_rf_sync_waits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_pd_mode == 2'd2 && !rf_powered_down && !rf_pump_idle) |=> !rf_powered_down);

  assert_if_power_up_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !if_pd_mode[1] |=> !if_powered_down);

  assert_rf_power_up_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rf_pd_mode[1] |=> !rf_powered_down);

  assert_osc_needs_both_R11: assert property (@(posedge clk) disable iff (!rst_n)
    osc_off |-> (if_pd_mode[1] && rf_pd_mode[1]));

  assert_if_hiz_mode_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (if_pd_mode == 2'd1 || if_powered_down) |-> if_pump_off);

  assert_rf_hiz_mode_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_pd_mode == 2'd1 || rf_powered_down) |-> rf_pump_off);

endmodule

bind synth_cfg_port synth_cfg_port_chk #(.REF_W(REF_W), .A_W(A_W), .B_W(B_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .le_rise(le_rise),
  .if_pump_idle(if_pump_idle), .rf_pump_idle(rf_pump_idle),
  .if_ref_div(if_ref_div), .if_ref_flags(if_ref_flags), .if_a(if_a), .if_b(if_b),
  .rf_ref_div(rf_ref_div), .rf_ref_flags(rf_ref_flags), .rf_a(rf_a), .rf_b(rf_b),
  .if_pd_mode(if_pd_mode), .rf_pd_mode(rf_pd_mode),
  .if_powered_down(if_powered_down), .rf_powered_down(rf_powered_down),
  .if_pump_off(if_pump_off), .rf_pump_off(rf_pump_off), .osc_off(osc_off)
);

// File: tb/synth_cfg_port_tb.sv
module synth_cfg_port_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
  logic if_pump_idle = 1'b0, rf_pump_idle = 1'b0;
  logic [14:0] if_ref_div, rf_ref_div;
  logic [4:0]  if_ref_flags, rf_ref_flags;
  logic [6:0]  if_a, rf_a;
  logic [10:0] if_b, rf_b;
  logic        if_presc_hi, rf_presc_hi;
  logic [1:0]  if_pd_mode, rf_pd_mode;
  logic        if_powered_down, rf_powered_down, if_pump_off, rf_pump_off, osc_off;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [19:0] m_ref [2];
  logic [19:0] m_div [2];

  always #5 clk = ~clk;

  synth_cfg_port u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
    .if_pump_idle(if_pump_idle), .rf_pump_idle(rf_pump_idle),
    .if_ref_div(if_ref_div), .if_ref_flags(if_ref_flags), .if_a(if_a), .if_b(if_b),
    .if_presc_hi(if_presc_hi), .if_pd_mode(if_pd_mode),
    .if_powered_down(if_powered_down), .if_pump_off(if_pump_off),
    .rf_ref_div(rf_ref_div), .rf_ref_flags(rf_ref_flags), .rf_a(rf_a), .rf_b(rf_b),
    .rf_presc_hi(rf_presc_hi), .rf_pd_mode(rf_pd_mode),
    .rf_powered_down(rf_powered_down), .rf_pump_off(rf_pump_off), .osc_off(osc_off)
  );

  // frames: {payload bit20..bit1, C1, C2}
  localparam logic [21:0] VEC [8] = '{
    {20'h03039, 2'b00},
    {20'hA7FFF, 2'b01},
    {20'h01FFF, 2'b10},
    {20'h40583, 2'b11},
    {20'h50003, 2'b00},
    {20'h00003, 2'b01},
    {20'h3FF80, 2'b10},
    {20'h3FFFF, 2'b11}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] bits, input int n, input bit load);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = bits[i];
      wait_clk(4);
      ser_clk = 1'b1;
      wait_clk(4);
      ser_clk = 1'b0;
    end
    wait_clk(4);
    if (load) begin
      ser_le = 1'b1;
      wait_clk(4);
      ser_le = 1'b0;
    end
    wait_clk(8);
  endtask

  function automatic logic [1:0] exp_mode(input logic r18, input logic n20);
    case ({r18, n20})
      2'b00:   return 2'd0;
      2'b10:   return 2'd1;
      2'b01:   return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  // bench model of the four registers (R3, R6 IF A keeps 4 bits)
  task automatic model_load(input logic [21:0] f);
    logic [19:0] p;
    int ch;
    p  = f[21:2];
    ch = int'(f[0]);
    if (f[1]) begin
      if (ch == 0) p[6:4] = 3'b000;
      m_div[ch] = p;
    end else begin
      m_ref[ch] = p;
    end
  endtask

  task automatic compare_model(input string tag);
    check({tag, " R5 IF ratio"}, 32'(if_ref_div), 32'(m_ref[0][14:0]));
    check({tag, " R5 IF flags"}, 32'(if_ref_flags), 32'(m_ref[0][19:15]));
    check({tag, " R5 RF ratio"}, 32'(rf_ref_div), 32'(m_ref[1][14:0]));
    check({tag, " R5 RF flags"}, 32'(rf_ref_flags), 32'(m_ref[1][19:15]));
    check({tag, " R6 IF A"}, 32'(if_a), 32'(m_div[0][6:0]));
    check({tag, " R6 IF B"}, 32'(if_b), 32'(m_div[0][17:7]));
    check({tag, " R6 IF presc"}, 32'(if_presc_hi), 32'(m_div[0][18]));
    check({tag, " R6 RF A"}, 32'(rf_a), 32'(m_div[1][6:0]));
    check({tag, " R6 RF B"}, 32'(rf_b), 32'(m_div[1][17:7]));
    check({tag, " R6 RF presc"}, 32'(rf_presc_hi), 32'(m_div[1][18]));
    check({tag, " R7 IF mode"}, 32'(if_pd_mode), 32'(exp_mode(m_ref[0][17], m_div[0][19])));
    check({tag, " R7 RF mode"}, 32'(rf_pd_mode), 32'(exp_mode(m_ref[1][17], m_div[1][19])));
  endtask

  task automatic frame(input logic [21:0] f);
    send_bits(32'(f), 22, 1'b1);
    model_load(f);
  endtask

  initial begin
    for (int c = 0; c < 2; c++) begin
      m_ref[c] = '0;
      m_div[c] = '0;
    end
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(2);

    // R1 reset state
    compare_model("R1 reset");
    check("R1 if_powered_down", 32'(if_powered_down), 0);
    check("R1 rf_powered_down", 32'(rf_powered_down), 0);
    check("R1 pump_off", 32'({if_pump_off, rf_pump_off}), 0);
    check("R1 osc_off", 32'(osc_off), 0);

    // R3 R5 R6: table of frames covering every address
    for (int v = 0; v < 8; v++) begin
      frame(VEC[v]);
      compare_model($sformatf("R3 vec%0d", v));
    end

    // R4: shifting without the load strobe changes nothing
    send_bits(32'({20'h7ABCD, 2'b11}), 22, 1'b0);
    compare_model("R4 no load");

    // R2: three extra leading bits are pushed out
    send_bits({7'b0, 3'b101, 20'h01234, 2'b01}, 25, 1'b1);
    model_load({20'h01234, 2'b01});
    compare_model("R2 long frame");

    // R7 R12: IF reference with pump high-Z flag, N20 clear
    frame({20'h20000 | 20'h00100, 2'b00});
    compare_model("R7 hiz");
    check("R7 if mode hiz", 32'(if_pd_mode), 1);
    check("R12 if pump_off hiz", 32'(if_pump_off), 1);
    check("R10 if not down", 32'(if_powered_down), 0);

    // R8: IF N20 set with R18 set, pump busy -> down at once
    frame({20'h80010, 2'b10});
    compare_model("R8 async");
    check("R8 if mode async", 32'(if_pd_mode), 3);
    check("R8 if powered_down", 32'(if_powered_down), 1);
    check("R11 osc_off one channel", 32'(osc_off), 0);

    // R9: RF reference R18 clear, RF N20 set, pump busy
    frame({20'h00040, 2'b01});
    frame({20'h80208, 2'b11});
    compare_model("R9 sync");
    check("R9 rf mode sync", 32'(rf_pd_mode), 2);
    check("R9 rf held up while busy", 32'(rf_powered_down), 0);
    check("R12 rf pump_off before down", 32'(rf_pump_off), 0);
    check("R11 osc_off both", 32'(osc_off), 1);
    wait_clk(10);
    check("R9 rf still up", 32'(rf_powered_down), 0);
    rf_pump_idle = 1'b1;
    wait_clk(2);
    check("R9 rf down after idle", 32'(rf_powered_down), 1);
    check("R12 rf pump_off when down", 32'(rf_pump_off), 1);
    rf_pump_idle = 1'b0;
    wait_clk(3);
    check("R9 rf stays down", 32'(rf_powered_down), 1);

    // R10 R11: clear IF N20
    frame({20'h00010, 2'b10});
    compare_model("R10 clear");
    check("R10 if powered up", 32'(if_powered_down), 0);
    check("R11 osc_off released", 32'(osc_off), 0);
    check("R12 if pump_off hiz kept", 32'(if_pump_off), 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule